// File: doc/BRIEF.md
# Partitioned SIMD Logical Shifter

A combinational logical shifter for a 32-bit word whose datapath can be split at runtime into independent lanes at byte boundaries. A three-bit partition mask selects which of the three inner byte boundaries are active. Bytes that have no active boundary between them merge into one wider lane, so a lane can be 8, 16, 24 or 32 bits wide. Every lane is shifted independently, and all lanes shift in the same direction.

Each lane takes its shift amount from the byte of the amount word at the lane's lowest byte position. Only as many low bits of that byte are used as the lane width needs. Bits never pass from one lane into another. Vacated positions are filled with zero. With no boundary active, the block is an ordinary 32-bit shifter. The width and the slice size are parameters, so the same structure can also serve as a 64-bit, eight-lane shifter.

Top module: `shift_partitioned`

## Requirements
- R1: Mask bit k (k = 0, 1, 2) enables the boundary at bit position 8*(k+1). A set bit separates the bytes on its two sides. Consecutive bytes with no set bit between them form one lane, so mask 3'b001 gives lane bits [7:0] and lane bits [31:8].
- R2: Each lane's shift amount is taken from amount-word bits [8*s+7:8*s], where s is the index of the lane's lowest byte.
- R3: A lane uses only the low 3 amount bits when it is 8 bits wide, the low 4 bits when it is 16 bits wide, and the low 5 bits when it is 24 or 32 bits wide. The higher bits of that amount byte have no effect.
- R4: A direction input of 0 shifts every lane toward the MSB (left). A direction input of 1 shifts every lane toward the LSB (right).
- R5: Shifts are logical. Vacated positions read zero, and bits shifted past a lane's edge are dropped. They never appear in a neighbouring lane.
- R6: With mask 3'b000, the output equals the 32-bit data word shifted by amount bits [4:0].
- R7: In a 24-bit lane, a 5-bit amount of 24 to 31 yields an all-zero lane.
- R8: The output is a combinational function of the inputs and follows them with no clock.
- R9: Amount bytes that are not the lowest byte of their lane have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 32 | Data word to be shifted |
| amt_i | input | 32 | Amount word; one byte per slice, and a lane reads its lowest slice's byte |
| dir_i | input | 1 | 0 = left, 1 = right, for all lanes |
| part_i | input | 3 | Boundary enables at bits 8, 16 and 24 |
| data_o | output | 32 | Lane-wise shifted result |

## Verification
The bench sweeps all eight partition masks in both directions, so every lane layout and direction is exercised. For each combination it applies amounts 0, 7, 15, 24, 31 and 255 to every byte, followed by random amounts and data. Zero shows that data passes through unchanged. The values 7, 15 and 31 sit at the edge of each lane width. The value 24 checks that a 24-bit lane empties. The value 255 shows that unused high amount bits are ignored. Directed cases change only the non-lowest amount bytes of a merged lane to confirm they are ignored, and check that the output moves with no clock edge. An all-ones data word with a shift of one confirms that no bit leaks across a lane boundary.

// File: rtl/shift_part_pkg.sv
package shift_part_pkg;

    // Number of amount bits needed to address a lane of the given width:
    // ceil(log2(lane_bits)).
    function automatic int amt_bits(input int lane_bits);
        int n;
        n = 0;
        for (int k = 15; k >= 0; k--) begin
            if ((1 << k) >= lane_bits) n = k;
        end
        return n;
    endfunction

endpackage

// File: rtl/shift_lane_map.sv
module shift_lane_map #(
    parameter int NSLICE = 4,
    localparam int CW = $clog2(NSLICE + 1)
) (
    input  logic [NSLICE-2:0] part_i,
    output logic [CW-1:0]     start_o [NSLICE],
    output logic [CW-1:0]     len_o   [NSLICE]
);

    always_comb begin
        for (int i = 0; i < NSLICE; i++) begin
            int s;
            int e;
            s = 0;
            for (int j = 1; j <= i; j++) begin
                if (part_i[j-1]) s = j;
            end
            e = NSLICE - 1;
            for (int j = NSLICE - 2; j >= i; j--) begin
                if (part_i[j]) e = j;
            end
            start_o[i] = CW'(s);
            len_o[i]   = CW'(e - s + 1);
        end
    end

endmodule

// File: rtl/shift_lane_unit.sv
module shift_lane_unit
    import shift_part_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SLICE_W = 8,
    parameter int IDX     = 0,
    localparam int NSLICE = WIDTH / SLICE_W,
    localparam int CW     = $clog2(NSLICE + 1)
) (
    input  logic [WIDTH-1:0]   data_i,
    input  logic [WIDTH-1:0]   amt_i,
    input  logic               dir_i,
    input  logic [CW-1:0]      start_i,
    input  logic [CW-1:0]      len_i,
    output logic [SLICE_W-1:0] slice_o
);

    logic [WIDTH-1:0]   lane_mask;
    logic [WIDTH-1:0]   lane_val;
    logic [WIDTH-1:0]   shifted;
    logic [SLICE_W-1:0] amt_byte;
    logic [SLICE_W-1:0] amount;
    int                 lane_bits;
    int                 nb;

    always_comb begin
        lane_mask = '0;
        for (int k = 0; k < NSLICE; k++) begin
            if (k < int'(len_i)) lane_mask[k*SLICE_W +: SLICE_W] = '1;
        end
        lane_bits = int'(len_i) * SLICE_W;
        nb        = amt_bits(lane_bits);
        amt_byte  = SLICE_W'(amt_i >> (int'(start_i) * SLICE_W));
        amount    = amt_byte & SLICE_W'((1 << nb) - 1);
        lane_val  = (data_i >> (int'(start_i) * SLICE_W)) & lane_mask;
        if (int'(amount) >= lane_bits) begin
            shifted = '0;
        end else if (dir_i) begin
            shifted = lane_val >> amount;
        end else begin
            shifted = (lane_val << amount) & lane_mask;
        end
        slice_o = SLICE_W'(shifted >> ((IDX - int'(start_i)) * SLICE_W));
    end

endmodule

// File: rtl/shift_partitioned.sv
module shift_partitioned #(
    parameter int WIDTH   = 32,
    parameter int SLICE_W = 8,
    localparam int NSLICE = WIDTH / SLICE_W
) (
    input  logic [WIDTH-1:0]  data_i,
    input  logic [WIDTH-1:0]  amt_i,
    input  logic              dir_i,
    input  logic [NSLICE-2:0] part_i,
    output logic [WIDTH-1:0]  data_o
);

    localparam int CW = $clog2(NSLICE + 1);

    logic [CW-1:0] lane_start [NSLICE];
    logic [CW-1:0] lane_len   [NSLICE];

    shift_lane_map #(.NSLICE(NSLICE)) u_map (
        .part_i  (part_i),
        .start_o (lane_start),
        .len_o   (lane_len)
    );

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        shift_lane_unit #(
            .WIDTH   (WIDTH),
            .SLICE_W (SLICE_W),
            .IDX     (g)
        ) u_unit (
            .data_i  (data_i),
            .amt_i   (amt_i),
            .dir_i   (dir_i),
            .start_i (lane_start[g]),
            .len_i   (lane_len[g]),
            .slice_o (data_o[g*SLICE_W +: SLICE_W])
        );
    end

endmodule

// File: rtl/shift_partitioned_chk.sv
module shift_partitioned_chk #(
    parameter int WIDTH   = 32,
    parameter int SLICE_W = 8,
    localparam int NSLICE = WIDTH / SLICE_W
) (
    input logic [WIDTH-1:0]  data_i,
    input logic [WIDTH-1:0]  amt_i,
    input logic              dir_i,
    input logic [NSLICE-2:0] part_i,
    input logic [WIDTH-1:0]  data_o
);

    localparam int FW = $clog2(WIDTH);
    localparam int SB = $clog2(SLICE_W);

    logic              known;
    logic              amt_low_zero;
    logic [FW-1:0]     full_amt;
    logic [SB-1:0]     top_amt;
    logic [SLICE_W-1:0] top_in;
    logic [SLICE_W-1:0] top_out;

    always_comb begin
        known        = !$isunknown({data_i, amt_i, dir_i, part_i, data_o});
        amt_low_zero = 1'b1;
        for (int k = 0; k < NSLICE; k++) begin
            if (amt_i[k*SLICE_W +: FW] != '0) amt_low_zero = 1'b0;
        end
        full_amt = amt_i[FW-1:0];
        top_amt  = amt_i[(NSLICE-1)*SLICE_W +: SB];
        top_in   = data_i[(NSLICE-1)*SLICE_W +: SLICE_W];
        top_out  = data_o[(NSLICE-1)*SLICE_W +: SLICE_W];

        if (known) begin
            // R6: no boundary active means a plain full-width shift
            p_full_width_r6: assert (part_i != '0 ||
                data_o == (dir_i ? (data_i >> full_amt) : (data_i << full_amt)))
                else $error("full-width shift mismatch");
            // R5: zero data can only produce zero
            p_zero_fill_r5: assert (data_i != '0 || data_o == '0)
                else $error("nonzero output from zero data");
            // R3: zero amounts leave the data unchanged in every layout
            p_zero_amount_r3: assert (!amt_low_zero || data_o == data_i)
                else $error("zero amount altered data");
            // R1: an isolated top slice depends only on its own byte
            p_top_lane_r1: assert (!part_i[NSLICE-2] ||
                top_out == (dir_i ? (top_in >> top_amt) : (top_in << top_amt)))
                else $error("isolated top lane mismatch");
            // R4: with all boundaries set, every byte shifts alone
            if (&part_i) begin
                for (int k = 0; k < NSLICE; k++) begin
                    p_byte_lane_r4: assert (data_o[k*SLICE_W +: SLICE_W] ==
                        (dir_i ? (data_i[k*SLICE_W +: SLICE_W] >> amt_i[k*SLICE_W +: SB])
                               : (data_i[k*SLICE_W +: SLICE_W] << amt_i[k*SLICE_W +: SB])))
                        else $error("byte lane mismatch");
                end
            end
        end
    end

endmodule

bind shift_partitioned shift_partitioned_chk #(
    .WIDTH   (WIDTH),
    .SLICE_W (SLICE_W)
) u_chk (
    .data_i (data_i),
    .amt_i  (amt_i),
    .dir_i  (dir_i),
    .part_i (part_i),
    .data_o (data_o)
);

// File: tb/shift_partitioned_tb.sv
module shift_partitioned_tb;

    logic        clk = 1'b0;
    logic [31:0] data_i;
    logic [31:0] amt_i;
    logic        dir_i;
    logic [2:0]  part_i;
    logic [31:0] data_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    shift_partitioned u_dut (
        .data_i (data_i),
        .amt_i  (amt_i),
        .dir_i  (dir_i),
        .part_i (part_i),
        .data_o (data_o)
    );

    // Reference: walk lanes from bit 0 upward, shift each with 64-bit math.
    function automatic logic [31:0] ref_shift(logic [31:0] d, logic [31:0] a,
                                              logic dr, logic [2:0] m);
        logic [31:0] res;
        int s;
        res = '0;
        s = 0;
        while (s < 4) begin
            int e;
            int w;
            int nb;
            longint unsigned v;
            longint unsigned sh;
            longint unsigned msk;
            e = s;
            while (e < 3 && !m[e]) e++;
            w   = (e - s + 1) * 8;
            nb  = (w == 8) ? 3 : (w == 16) ? 4 : 5;
            sh  = longint'(a[s*8 +: 8]) & ((64'd1 << nb) - 1);
            msk = (64'd1 << w) - 1;
            v   = (longint'(d) >> (s * 8)) & msk;
            v   = dr ? (v >> sh) : ((v << sh) & msk);
            for (int b = s; b <= e; b++) res[b*8 +: 8] = 8'(v >> ((b - s) * 8));
            s = e + 1;
        end
        return res;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h (data %h amt %h dir %0b mask %b)",
                     tag, got, exp, data_i, amt_i, dir_i, part_i);
        end
    endtask

    task automatic apply(logic [31:0] d, logic [31:0] a, logic dr, logic [2:0] m);
        @(negedge clk);
        data_i = d;
        amt_i  = a;
        dir_i  = dr;
        part_i = m;
        #1;
    endtask

    initial begin
        logic [31:0] first;
        data_i = '0;
        amt_i  = '0;
        dir_i  = 1'b0;
        part_i = '0;
        repeat (2) @(negedge clk);
        check("R5 reset-state zero output", data_o, 32'h0);

        // Main sweep: every mask, both directions, edge and random amounts
        for (int m = 0; m < 8; m++) begin
            for (int dr = 0; dr < 2; dr++) begin
                logic [7:0] edges [6];
                edges = '{8'd0, 8'd7, 8'd15, 8'd24, 8'd31, 8'd255};
                for (int k = 0; k < 6; k++) begin
                    logic [31:0] d;
                    d = $urandom;
                    apply(d, {4{edges[k]}}, dr[0], m[2:0]);
                    if (m == 0)            check("R6 plain shift edge amount", data_o, ref_shift(d, amt_i, dr[0], m[2:0]));
                    else if (edges[k] == 24) check("R7 24-bit lane amount>=24", data_o, ref_shift(d, amt_i, dr[0], m[2:0]));
                    else if (edges[k] == 255) check("R3 high amount bits ignored", data_o, ref_shift(d, amt_i, dr[0], m[2:0]));
                    else                   check("R4 direction edge amount", data_o, ref_shift(d, amt_i, dr[0], m[2:0]));
                end
                for (int r = 0; r < 20; r++) begin
                    apply($urandom, $urandom, dr[0], m[2:0]);
                    check("R2 random lane amounts", data_o, ref_shift(data_i, amt_i, dr[0], m[2:0]));
                end
                apply(32'hFFFF_FFFF, 32'h0101_0101, dr[0], m[2:0]);
                check("R5 no bit crosses a boundary", data_o, ref_shift(data_i, amt_i, dr[0], m[2:0]));
            end
        end

        // R1: mask 001 gives an 8-bit lane and a 24-bit lane
        apply(32'h0000_8081, 32'h0000_0101, 1'b0, 3'b001);
        check("R1 mask 001 layout", data_o, 32'h0001_0002);

        // R6: fixed case
        apply(32'h1234_5678, 32'hFFFF_FF04, 1'b1, 3'b000);
        check("R6 plain right shift by 4", data_o, 32'h0123_4567);

        // R7: 24-bit lane, amount 24 empties it (mask 100, lane [23:0])
        apply(32'hAB12_3456, 32'h0300_0018, 1'b0, 3'b100);
        check("R7 24-bit lane emptied", data_o, 32'h5800_0000);

        // R9: non-lowest bytes of a merged lane have no effect
        apply(32'hCAFE_F00D, 32'h0000_0005, 1'b0, 3'b000);
        first = data_o;
        apply(32'hCAFE_F00D, 32'h7F3C_A905, 1'b0, 3'b000);
        check("R9 upper amount bytes ignored", data_o, first);
        apply(32'hCAFE_F00D, 32'h0003_0002, 1'b1, 3'b010);
        first = data_o;
        apply(32'hCAFE_F00D, 32'hEE03_1102, 1'b1, 3'b010);
        check("R9 upper amount bytes ignored in 16-bit lanes", data_o, first);

        // R8: output follows inputs without any clock edge
        @(posedge clk);
        #1;
        data_i = 32'h0000_00F0;
        amt_i  = 32'h0000_0004;
        dir_i  = 1'b1;
        part_i = 3'b111;
        #1;
        check("R8 combinational response", data_o, 32'h0000_000F);

        done = 1'b1;
    end

    initial begin
        int cycles;
        cycles = 0;
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule